// File: doc/BRIEF.md
# Instruction Fetch and Rename Stage

This stage runs at the front of an out-of-order core. Each cycle it presents a fetch address to a small external instruction memory and takes back the instruction word. It decodes the word and predicts the address to fetch next. Source registers are resolved into either a ready value or the tag of the in-flight producer. The result is a template entry for the tail of a reorder buffer. A result-producing instruction is given a fresh tag, and the destination register is remapped to that tag in an internal rename table. Conditional jumps take their next address from a per-address target table, which is loaded through a write port. Every other instruction goes to the next sequential address.

The reorder buffer holds off fetch by raising a full flag. While it is raised, the stage presents no valid entry and keeps its address, tag counter and rename mappings. Commits from the buffer come back into the stage. A commit clears a rename mapping only when that mapping still points at the committing tag. A commit in the same cycle as a lookup of that register forwards the committed value, so the entry never picks up a tag that is about to retire.

Instruction word, 16 bits: opcode [15:12], destination register [11:9], first source [8:6], second source [5:3]. The constant for a load-constant is [8:0], zero-extended. Opcodes: 0 load-constant, 1 load-pc, 2 to 7 arithmetic, 8 conditional jump, 9 load, 10 store. Any other code is a no-operation.

Top module: `fetch_rename`

## Requirements
- R1: For any valid entry that is not a conditional jump (opcode 8), the next fetch address is the current address plus one, wrapping from 15 to 0.
- R2: For a conditional jump, the next fetch address is the target-table entry indexed by the current address, and ent_spc_o carries that same address.
- R3: A load-constant entry has ent_val_rdy_o=1 and ent_val_o equal to the zero-extended bits [8:0]. A load-pc entry has ent_val_rdy_o=1 and ent_val_o equal to the current address. All other entries have ent_val_rdy_o=0.
- R4: A used source whose register has no mapping gives rdy=1 with the register-file value. A mapped register gives rdy=0 with the producer tag in the low bits. An unused source gives rdy=1 and value 0.
- R5: Tags are handed out in increasing order, modulo 8. One tag is taken by each load-constant, load-pc, arithmetic, load and store entry that is accepted. Jumps and no-operations take none.
- R6: While rob_full_i=1, out_valid_o=0, and the fetch address, tag counter and rename mappings made by fetch do not change.
- R7: Load and store entries have ent_mem_pend_o=1 (memory access not yet done). All other entries have ent_mem_pend_o=0.
- R8: A commit clears a register's mapping only when cmt_tag_i equals the tag currently mapped for cmt_reg_i. Otherwise the mapping is kept.
- R9: When a source register's mapping matches a commit in the same cycle, the source gives rdy=1 with cmt_data_i.
- R10: Reset sets the fetch address to 0 and the tag counter to 0, clears all mappings and the target table, and holds out_valid_o at 0.
- R11: A target-table write (btb_we_i) stores btb_wdata_i at btb_waddr_i, and the write takes effect for the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word at pc_o |
| rob_full_i | input | 1 | Reorder buffer cannot accept an entry |
| btb_we_i | input | 1 | Target table write enable |
| btb_waddr_i | input | 4 | Target table write index |
| btb_wdata_i | input | 4 | Target address to store |
| rf_rdata1_i | input | 16 | Register file value for rf_raddr1_o |
| rf_rdata2_i | input | 16 | Register file value for rf_raddr2_o |
| cmt_valid_i | input | 1 | An entry commits this cycle |
| cmt_reg_i | input | 3 | Destination register of the committing entry |
| cmt_tag_i | input | 3 | Tag of the committing entry |
| cmt_data_i | input | 16 | Value of the committing entry |
| pc_o | output | 4 | Current fetch address |
| next_pc_o | output | 4 | Predicted next fetch address |
| rf_raddr1_o | output | 3 | First source register |
| rf_raddr2_o | output | 3 | Second source register |
| out_valid_o | output | 1 | Entry valid and accepted this cycle |
| ent_opc_o | output | 4 | Entry opcode |
| ent_tag_vld_o | output | 1 | Entry takes a tag |
| ent_dst_tag_o | output | 3 | Tag given to the entry |
| ent_wr_reg_o | output | 1 | Entry writes a register |
| ent_dst_reg_o | output | 3 | Destination register |
| ent_val_rdy_o | output | 1 | Result already known |
| ent_val_o | output | 16 | Known result |
| ent_s1_rdy_o | output | 1 | First source holds a value |
| ent_s1_o | output | 16 | First source value or tag |
| ent_s2_rdy_o | output | 1 | Second source holds a value |
| ent_s2_o | output | 16 | Second source value or tag |
| ent_spc_o | output | 4 | Speculated next address of a jump |
| ent_mem_pend_o | output | 1 | Memory access not yet done |

## Verification
The hardest case to reach is a commit that lands in the same cycle as a lookup of the committed register. The lookup then has to forward the value, and after that edge the mapping must be gone. A commit with an old tag must leave a newer mapping alone. To reach these cases, the stimulus first builds real mappings with a run of dispatches. It then holds the buffer full so the fetch address stays put. While fetch is held, it plays matching and stale commits against one instruction and watches the source fields cycle by cycle. A stall in the middle of the dispatch run, a jump through a preloaded target, and address wrap complete the sequence.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_LDC    = 4'h0;
  localparam logic [OPC_W-1:0] OPC_LDPC   = 4'h1;
  localparam logic [OPC_W-1:0] OPC_ALU_LO = 4'h2;
  localparam logic [OPC_W-1:0] OPC_ALU_HI = 4'h7;
  localparam logic [OPC_W-1:0] OPC_JZ     = 4'h8;
  localparam logic [OPC_W-1:0] OPC_LD     = 4'h9;
  localparam logic [OPC_W-1:0] OPC_ST     = 4'hA;

  typedef struct packed {
    logic use_s1;
    logic use_s2;
    logic wr_reg;
    logic alloc;
    logic is_jz;
    logic is_mem;
    logic val_imm;
    logic val_pc;
  } dec_t;
endpackage

// File: rtl/fr_decode.sv
module fr_decode
  import fr_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output dec_t             dec_o
);
  always_comb begin
    dec_o = '0;
    case (opc_i)
      OPC_LDC:  begin dec_o.wr_reg = 1'b1; dec_o.alloc = 1'b1; dec_o.val_imm = 1'b1; end
      OPC_LDPC: begin dec_o.wr_reg = 1'b1; dec_o.alloc = 1'b1; dec_o.val_pc = 1'b1; end
      OPC_JZ:   begin dec_o.use_s1 = 1'b1; dec_o.use_s2 = 1'b1; dec_o.is_jz = 1'b1; end
      OPC_LD:   begin
        dec_o.use_s1 = 1'b1; dec_o.wr_reg = 1'b1; dec_o.alloc = 1'b1; dec_o.is_mem = 1'b1;
      end
      OPC_ST:   begin
        dec_o.use_s1 = 1'b1; dec_o.use_s2 = 1'b1; dec_o.alloc = 1'b1; dec_o.is_mem = 1'b1;
      end
      default: begin
        if (opc_i >= OPC_ALU_LO && opc_i <= OPC_ALU_HI) begin
          dec_o.use_s1 = 1'b1; dec_o.use_s2 = 1'b1;
          dec_o.wr_reg = 1'b1; dec_o.alloc  = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/fr_btb.sv
module fr_btb #(
  parameter int DEPTH = 16,
  parameter int PC_W  = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [PC_W-1:0] waddr_i,
  input  logic [PC_W-1:0] wdata_i,
  input  logic [PC_W-1:0] raddr_i,
  output logic [PC_W-1:0] rdata_o
);
  logic [PC_W-1:0] tgt_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tgt_q[i] <= '0;
    end else if (we_i) begin
      tgt_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = tgt_q[raddr_i];
endmodule

// File: rtl/fr_rename.sv
module fr_rename #(
  parameter int NREG   = 8,
  parameter int NTAG   = 8,
  parameter int DATA_W = 16,
  parameter int NRD    = 2,
  localparam int RW    = $clog2(NREG),
  localparam int TAG_W = $clog2(NTAG)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NRD-1:0][RW-1:0]     rd_reg_i,
  input  logic [NRD-1:0][DATA_W-1:0] rf_data_i,
  output logic [NRD-1:0]             rd_rdy_o,
  output logic [NRD-1:0][DATA_W-1:0] rd_val_o,
  input  logic                       wr_en_i,
  input  logic [RW-1:0]              wr_reg_i,
  input  logic [TAG_W-1:0]           wr_tag_i,
  input  logic                       cmt_vld_i,
  input  logic [RW-1:0]              cmt_reg_i,
  input  logic [TAG_W-1:0]           cmt_tag_i,
  input  logic [DATA_W-1:0]          cmt_data_i
);
  logic [NREG-1:0]  map_vld_q;
  logic [TAG_W-1:0] map_tag_q [NREG];
  logic             cmt_hit;

  assign cmt_hit = cmt_vld_i && map_vld_q[cmt_reg_i] && (map_tag_q[cmt_reg_i] == cmt_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_vld_q <= '0;
      for (int r = 0; r < NREG; r++) map_tag_q[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wr_en_i && wr_reg_i == RW'(r)) begin
          map_vld_q[r] <= 1'b1;
          map_tag_q[r] <= wr_tag_i;
        end else if (cmt_hit && cmt_reg_i == RW'(r)) begin
          map_vld_q[r] <= 1'b0;
        end
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_lookup
    always_comb begin
      if (cmt_hit && cmt_reg_i == rd_reg_i[p]) begin
        rd_rdy_o[p] = 1'b1;
        rd_val_o[p] = cmt_data_i;          // retiring this cycle
      end else if (map_vld_q[rd_reg_i[p]]) begin
        rd_rdy_o[p] = 1'b0;
        rd_val_o[p] = DATA_W'(map_tag_q[rd_reg_i[p]]);
      end else begin
        rd_rdy_o[p] = 1'b1;
        rd_val_o[p] = rf_data_i[p];
      end
    end
  end
endmodule

// File: rtl/fetch_rename.sv
module fetch_rename
  import fr_pkg::*;
#(
  parameter int IMEM_DEPTH = 16,
  parameter int NREG       = 8,
  parameter int NTAG       = 8,
  parameter int DATA_W     = 16,
  parameter int INSTR_W    = 16,
  localparam int PC_W      = $clog2(IMEM_DEPTH),
  localparam int RW        = $clog2(NREG),
  localparam int TAG_W     = $clog2(NTAG),
  localparam int IMM_W     = INSTR_W - OPC_W - RW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               rob_full_i,
  input  logic               btb_we_i,
  input  logic [PC_W-1:0]    btb_waddr_i,
  input  logic [PC_W-1:0]    btb_wdata_i,
  input  logic [DATA_W-1:0]  rf_rdata1_i,
  input  logic [DATA_W-1:0]  rf_rdata2_i,
  input  logic               cmt_valid_i,
  input  logic [RW-1:0]      cmt_reg_i,
  input  logic [TAG_W-1:0]   cmt_tag_i,
  input  logic [DATA_W-1:0]  cmt_data_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [PC_W-1:0]    next_pc_o,
  output logic [RW-1:0]      rf_raddr1_o,
  output logic [RW-1:0]      rf_raddr2_o,
  output logic               out_valid_o,
  output logic [OPC_W-1:0]   ent_opc_o,
  output logic               ent_tag_vld_o,
  output logic [TAG_W-1:0]   ent_dst_tag_o,
  output logic               ent_wr_reg_o,
  output logic [RW-1:0]      ent_dst_reg_o,
  output logic               ent_val_rdy_o,
  output logic [DATA_W-1:0]  ent_val_o,
  output logic               ent_s1_rdy_o,
  output logic [DATA_W-1:0]  ent_s1_o,
  output logic               ent_s2_rdy_o,
  output logic [DATA_W-1:0]  ent_s2_o,
  output logic [PC_W-1:0]    ent_spc_o,
  output logic               ent_mem_pend_o
);
  localparam int NSRC = 2;

  logic [PC_W-1:0]  pc_q;
  logic [TAG_W-1:0] tag_q;
  logic             run_q;
  logic             fire;
  dec_t             dec;
  logic [PC_W-1:0]  btb_tgt;

  logic [OPC_W-1:0] f_opc;
  logic [RW-1:0]    f_rd;
  logic [IMM_W-1:0] f_imm;

  logic [NSRC-1:0][RW-1:0]     src_reg;
  logic [NSRC-1:0][DATA_W-1:0] src_rf;
  logic [NSRC-1:0]             lk_rdy;
  logic [NSRC-1:0][DATA_W-1:0] lk_val;
  logic [NSRC-1:0]             src_use;
  logic [NSRC-1:0]             s_rdy;
  logic [NSRC-1:0][DATA_W-1:0] s_val;

  assign f_opc = instr_i[INSTR_W-1 -: OPC_W];
  assign f_rd  = instr_i[INSTR_W-OPC_W-1 -: RW];
  assign f_imm = instr_i[IMM_W-1:0];
  assign src_reg[0] = instr_i[INSTR_W-OPC_W-RW-1 -: RW];
  assign src_reg[1] = instr_i[INSTR_W-OPC_W-2*RW-1 -: RW];
  assign src_rf[0]  = rf_rdata1_i;
  assign src_rf[1]  = rf_rdata2_i;

  fr_decode u_dec (.opc_i(f_opc), .dec_o(dec));

  fr_btb #(.DEPTH(IMEM_DEPTH)) u_btb (
    .clk_i, .rst_ni,
    .we_i(btb_we_i), .waddr_i(btb_waddr_i), .wdata_i(btb_wdata_i),
    .raddr_i(pc_q), .rdata_o(btb_tgt)
  );

  assign fire = run_q && !rob_full_i;

  fr_rename #(.NREG(NREG), .NTAG(NTAG), .DATA_W(DATA_W), .NRD(NSRC)) u_ren (
    .clk_i, .rst_ni,
    .rd_reg_i(src_reg), .rf_data_i(src_rf),
    .rd_rdy_o(lk_rdy), .rd_val_o(lk_val),
    .wr_en_i(fire && dec.wr_reg), .wr_reg_i(f_rd), .wr_tag_i(tag_q),
    .cmt_vld_i(cmt_valid_i), .cmt_reg_i(cmt_reg_i),
    .cmt_tag_i(cmt_tag_i), .cmt_data_i(cmt_data_i)
  );

  assign src_use = {dec.use_s2, dec.use_s1};
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign s_rdy[s] = src_use[s] ? lk_rdy[s] : 1'b1;
    assign s_val[s] = src_use[s] ? lk_val[s] : '0;
  end

  assign next_pc_o = dec.is_jz ? btb_tgt : pc_q + PC_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      tag_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (fire) begin
        pc_q <= next_pc_o;
        if (dec.alloc) tag_q <= tag_q + TAG_W'(1);
      end
    end
  end

  assign pc_o           = pc_q;
  assign rf_raddr1_o    = src_reg[0];
  assign rf_raddr2_o    = src_reg[1];
  assign out_valid_o    = fire;
  assign ent_opc_o      = f_opc;
  assign ent_tag_vld_o  = dec.alloc;
  assign ent_dst_tag_o  = tag_q;
  assign ent_wr_reg_o   = dec.wr_reg;
  assign ent_dst_reg_o  = f_rd;
  assign ent_val_rdy_o  = dec.val_imm || dec.val_pc;
  assign ent_val_o      = dec.val_imm ? DATA_W'(f_imm) :
                          dec.val_pc  ? DATA_W'(pc_q)  : '0;
  assign ent_s1_rdy_o   = s_rdy[0];
  assign ent_s1_o       = s_val[0];
  assign ent_s2_rdy_o   = s_rdy[1];
  assign ent_s2_o       = s_val[1];
  assign ent_spc_o      = dec.is_jz ? btb_tgt : '0;
  assign ent_mem_pend_o = dec.is_mem;
endmodule

// File: rtl/fetch_rename_chk.sv
module fetch_rename_chk
  import fr_pkg::*;
#(
  parameter int PC_W  = 4,
  parameter int TAG_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rob_full_i,
  input logic             out_valid_o,
  input logic [PC_W-1:0]  pc_o,
  input logic [OPC_W-1:0] ent_opc_o,
  input logic             ent_tag_vld_o,
  input logic [TAG_W-1:0] ent_dst_tag_o,
  input logic             ent_val_rdy_o,
  input logic [PC_W-1:0]  ent_spc_o
);
  AST_STALL_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rob_full_i |=> $stable(pc_o)); // R6

  AST_STALL_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rob_full_i |=> $stable(ent_dst_tag_o)); // R6

  AST_FULL_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rob_full_i |-> !out_valid_o); // R6

  AST_SEQ_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && ent_opc_o != OPC_JZ) |=> pc_o == $past(pc_o) + PC_W'(1)); // R1

  AST_JZ_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && ent_opc_o == OPC_JZ) |=> pc_o == $past(ent_spc_o)); // R2

  AST_TAG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && ent_tag_vld_o) |=> ent_dst_tag_o == $past(ent_dst_tag_o) + TAG_W'(1)); // R5

  AST_NO_TAG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !ent_tag_vld_o) |=> $stable(ent_dst_tag_o)); // R5

  AST_CONST_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_opc_o == OPC_LDC || ent_opc_o == OPC_LDPC) |-> ent_val_rdy_o); // R3
endmodule

bind fetch_rename fetch_rename_chk #(.PC_W(PC_W), .TAG_W(TAG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rob_full_i(rob_full_i),
  .out_valid_o(out_valid_o), .pc_o(pc_o), .ent_opc_o(ent_opc_o),
  .ent_tag_vld_o(ent_tag_vld_o), .ent_dst_tag_o(ent_dst_tag_o),
  .ent_val_rdy_o(ent_val_rdy_o), .ent_spc_o(ent_spc_o)
);

// File: tb/sim_fetch_rename.sv
module sim_fetch_rename;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] instr = '0;
  logic        full = 1'b1;
  logic        btb_we = 1'b0;
  logic [3:0]  btb_waddr = '0, btb_wdata = '0;
  logic [15:0] rf1, rf2;
  logic        cmt_v = 1'b0;
  logic [2:0]  cmt_reg = '0, cmt_tag = '0;
  logic [15:0] cmt_data = '0;
  logic [3:0]  pc, npc, spc;
  logic [2:0]  ra1, ra2, dtag, dreg;
  logic        valid, tag_vld, wr_reg, vrdy, s1r, s2r, mem;
  logic [3:0]  opc;
  logic [15:0] val, s1, s2;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign rf1 = 16'hA000 | {13'b0, ra1};
  assign rf2 = 16'hA000 | {13'b0, ra2};

  fetch_rename u0 (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr), .rob_full_i(full),
    .btb_we_i(btb_we), .btb_waddr_i(btb_waddr), .btb_wdata_i(btb_wdata),
    .rf_rdata1_i(rf1), .rf_rdata2_i(rf2),
    .cmt_valid_i(cmt_v), .cmt_reg_i(cmt_reg), .cmt_tag_i(cmt_tag), .cmt_data_i(cmt_data),
    .pc_o(pc), .next_pc_o(npc), .rf_raddr1_o(ra1), .rf_raddr2_o(ra2),
    .out_valid_o(valid), .ent_opc_o(opc), .ent_tag_vld_o(tag_vld),
    .ent_dst_tag_o(dtag), .ent_wr_reg_o(wr_reg), .ent_dst_reg_o(dreg),
    .ent_val_rdy_o(vrdy), .ent_val_o(val),
    .ent_s1_rdy_o(s1r), .ent_s1_o(s1), .ent_s2_rdy_o(s2r), .ent_s2_o(s2),
    .ent_spc_o(spc), .ent_mem_pend_o(mem)
  );

  typedef struct packed {
    logic [15:0] ins;
    logic        full;
    logic        vld;
    logic [3:0]  pc;
    logic [3:0]  npc;
    logic [2:0]  tag;
    logic        vr;
    logic [15:0] val;
    logic        s1r;
    logic [15:0] s1;
    logic        s2r;
    logic [15:0] s2;
    logic        mem;
  } vec_t;

  // runs from pc 0 after reset, target table[3] = 12
  localparam vec_t VT [9] = '{
    '{16'h0205, 1'b0, 1'b1, 4'h0, 4'h1, 3'd0, 1'b1, 16'h0005, 1'b1, 16'h0000, 1'b1, 16'h0000, 1'b0},
    '{16'h2458, 1'b0, 1'b1, 4'h1, 4'h2, 3'd1, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'hA003, 1'b0},
    '{16'h2888, 1'b1, 1'b0, 4'h2, 4'h3, 3'd2, 1'b0, 16'h0000, 1'b0, 16'h0001, 1'b0, 16'h0000, 1'b0},
    '{16'h2888, 1'b0, 1'b1, 4'h2, 4'h3, 3'd2, 1'b0, 16'h0000, 1'b0, 16'h0001, 1'b0, 16'h0000, 1'b0},
    '{16'h8128, 1'b0, 1'b1, 4'h3, 4'hC, 3'd3, 1'b0, 16'h0000, 1'b0, 16'h0002, 1'b1, 16'hA005, 1'b0},
    '{16'h1C00, 1'b0, 1'b1, 4'hC, 4'hD, 3'd3, 1'b1, 16'h000C, 1'b1, 16'h0000, 1'b1, 16'h0000, 1'b0},
    '{16'h9F80, 1'b0, 1'b1, 4'hD, 4'hE, 3'd4, 1'b0, 16'h0000, 1'b0, 16'h0003, 1'b1, 16'h0000, 1'b1},
    '{16'hA1C8, 1'b0, 1'b1, 4'hE, 4'hF, 3'd5, 1'b0, 16'h0000, 1'b0, 16'h0004, 1'b0, 16'h0000, 1'b1},
    '{16'h3600, 1'b0, 1'b1, 4'hF, 4'h0, 3'd6, 1'b0, 16'h0000, 1'b1, 16'hA000, 1'b1, 16'hA000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    @(negedge clk); @(negedge clk);
    #1;
    chk("R10 pc", pc, 4'h0);
    chk("R10 valid", valid, 1'b0);
    chk("R10 tag", dtag, 3'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    // R11: preload target[3]=12 while held full
    btb_we = 1'b1; btb_waddr = 4'h3; btb_wdata = 4'hC;
    @(negedge clk);
    btb_we = 1'b0;
    #1;
    chk("R6 pc held during preload", pc, 4'h0);

    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      instr = VT[i].ins;
      full  = VT[i].full;
      #1;
      chk("R6 valid", valid, VT[i].vld);
      chk("R1 pc", pc, VT[i].pc);
      chk("R1 R2 next_pc", npc, VT[i].npc);
      chk("R5 tag", dtag, VT[i].tag);
      chk("R3 val_rdy", vrdy, VT[i].vr);
      chk("R3 val", val, VT[i].val);
      chk("R4 s1_rdy", s1r, VT[i].s1r);
      chk("R4 s1", s1, VT[i].s1);
      chk("R4 s2_rdy", s2r, VT[i].s2r);
      chk("R4 s2", s2, VT[i].s2);
      chk("R7 mem_pend", mem, VT[i].mem);
      if (VT[i].ins[15:12] == 4'h8) chk("R11 R2 spc", spc, 4'hC);
    end

    // commit tests, fetch held at pc 0; r1->tag0, r2->tag1
    @(negedge clk);
    instr = 16'h2A50; full = 1'b1;
    cmt_v = 1'b1; cmt_reg = 3'd1; cmt_tag = 3'd0; cmt_data = 16'h0077;
    #1;
    chk("R9 bypass rdy", s1r, 1'b1);
    chk("R9 bypass val", s1, 16'h0077);
    chk("R4 s2 tag", s2, 16'h0001);
    @(negedge clk);
    cmt_v = 1'b0;
    #1;
    chk("R8 cleared rdy", s1r, 1'b1);
    chk("R8 cleared val", s1, 16'hA001);
    @(negedge clk);
    cmt_v = 1'b1; cmt_reg = 3'd2; cmt_tag = 3'd5; cmt_data = 16'h0055;
    #1;
    chk("R9 stale no bypass", s2r, 1'b0);
    @(negedge clk);
    cmt_v = 1'b0;
    #1;
    chk("R8 stale kept rdy", s2r, 1'b0);
    chk("R8 stale kept tag", s2, 16'h0001);
    chk("R6 pc held", pc, 4'h0);
    chk("R6 tag held", dtag, 3'd7);
    chk("R6 no valid", valid, 1'b0);

    // R10: reset mid-run clears mappings and counters
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R10 pc after reset", pc, 4'h0);
    chk("R10 tag after reset", dtag, 3'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R10 map cleared s1", s1, 16'hA001);
    chk("R10 map cleared s2", s2, 16'hA002);
    chk("R10 map cleared s2 rdy", s2r, 1'b1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule